// File: doc/BRIEF.md
# Receive Descriptor List Walker

This block walks a list of receive descriptors that software has placed in host memory. Each descriptor is four consecutive 32-bit words: a status word, a control word with two 11-bit buffer lengths and two list-control flags, the address of the first data buffer, and a fourth word that is either the address of a second data buffer or a pointer to the next descriptor. The walker reads the four words through a simple request/acknowledge read port. If the owner flag in the status word is clear, it waits and polls the status word again. Once it holds a descriptor, it accepts the byte count of an incoming frame.

The walker divides the frame across the buffers the descriptor offers. For each buffer it issues one DMA request, which carries a buffer address and a byte count. A buffer with a zero length is skipped. A frame that does not fit continues into the next descriptor. After the walker has used a descriptor, it writes the status word back. The written word has the owner flag cleared, first-segment and last-segment marks, and the error flags of the frame. The CRC and FIFO-overflow flags are written only into the ending descriptor.

The next descriptor address depends on the control word. With the end-of-ring flag set, the walker returns to the list base. In chained mode, it follows the pointer held in the fourth word. Otherwise it steps 16 bytes forward.

Top module: `rxw_walker`

## Requirements
- R1: After reset the block raises no memory read, memory write or DMA request and keeps `frm_ready` low. It leaves the idle state only when `run_en` is high, and it then starts at `list_base`.
- R2: A descriptor at address A is read as four words at A, A+4, A+8 and A+12, in that order. Word 1 carries the buffer 1 length in bits [10:0] and the buffer 2 length in bits [21:11]. Word 2 is the buffer 1 address and word 3 is the buffer 2 address.
- R3: Bit 31 of word 0 is the owner flag. While it reads as 0, the block keeps re-reading word 0 at the same address, does not advance to word 1, and does not raise `frm_ready`.
- R4: `frm_ready` is high only when an owned descriptor has been fully read and no frame is in progress. No memory or DMA request is active at the same time as `frm_ready`.
- R5: The first DMA request of a descriptor uses the word 2 address, and its length is the smaller of the remaining frame bytes and the buffer 1 length.
- R6: In ring mode (word 1 bit 24 clear), bytes that remain after buffer 1 go to buffer 2. That request uses the word 3 address and the smaller of the remaining bytes and the buffer 2 length. Bytes that still remain continue in the next descriptor.
- R7: In chained mode (word 1 bit 24 set), only buffer 1 carries data, and the buffer 2 length is ignored. No DMA request is ever made to the word 3 address.
- R8: The next descriptor address is chosen in this priority order. If word 1 bit 25 (end of ring) is set, it is `list_base`. Otherwise, if bit 24 is set, it is word 3. Otherwise it is the current address plus 16.
- R9: A buffer whose length field is zero gets no DMA request. No DMA request ever has a zero length.
- R10: After it has used a descriptor, the block writes its word 0 with these fields: bit 31 cleared; bit 9 set if the frame started in this descriptor; bit 8 set if the frame ended in it; bits 3 (physical-layer error) and 2 (non-byte-boundary end) copied from `frm_err[3:2]`. All other bits are zero.
- R11: Bits 1 (CRC error) and 0 (FIFO overflow) are copied from `frm_err[1:0]` only in the ending descriptor (bit 8 set). In any other descriptor they are written as 0.
- R12: A DMA request holds its address and length unchanged until `dma_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Starts the walk from the idle state |
| list_base | input | AW | Byte address of the first descriptor; also the end-of-ring return address |
| mem_rd_req | output | 1 | Read request for one descriptor word |
| mem_rd_addr | output | AW | Byte address of the requested word |
| mem_rd_ack | input | 1 | Read accepted; `mem_rd_data` is valid in this cycle |
| mem_rd_data | input | 32 | Read data |
| mem_wr_req | output | 1 | Status writeback request |
| mem_wr_addr | output | AW | Byte address of the status word written back |
| mem_wr_data | output | 32 | Status word written back |
| mem_wr_ack | input | 1 | Write accepted |
| frm_valid | input | 1 | A received frame's length and errors are offered |
| frm_ready | output | 1 | The walker takes the offered frame in this cycle |
| frm_len | input | FLW | Frame length in bytes |
| frm_err | input | 4 | Error flags: [3] physical layer, [2] non-byte end, [1] CRC, [0] FIFO overflow |
| dma_req | output | 1 | DMA request for one buffer segment |
| dma_addr | output | AW | Buffer start address |
| dma_len | output | 11 | Segment length in bytes |
| dma_ack | input | 1 | DMA request accepted |

## Verification
The properties assume three things about the inputs. Each acknowledge rises only while its matching request is high. Read data is valid in the cycle its acknowledge is seen. `frm_valid` stays up with steady length and errors until `frm_ready` is seen. The bench meets these by deriving every acknowledge from the request it observes at the falling edge, and by holding the frame inputs in a loop until the walker takes them. The DMA responder waits two cycles before it acknowledges, so the hold rule for a stalled request is exercised. The list mixes ring, chained, end-of-ring, zero-length and not-yet-owned descriptors, and the bench releases one stalled descriptor while the walker is polling it.

// File: rtl/rxw_pkg.sv
package rxw_pkg;

  localparam int LEN_W      = 11;
  localparam int WORD_W     = 32;
  localparam int DESC_BYTES = 16;

  localparam int OWN_BIT    = 31;
  localparam int EOR_BIT    = 25;
  localparam int CHN_BIT    = 24;
  localparam int FIRST_BIT  = 9;
  localparam int LAST_BIT   = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAITF,
    ST_BUF1,
    ST_BUF2,
    ST_WBACK
  } rxw_state_e;

endpackage

// File: rtl/rxw_next_addr.sv
module rxw_next_addr #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] base_addr,
  input  logic [AW-1:0] chain_ptr,
  input  logic          end_ring,
  input  logic          chained,
  output logic [AW-1:0] next_addr
);
  import rxw_pkg::*;

  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  always_comb begin
    if (end_ring) begin
      next_addr = base_addr;
    end else if (chained) begin
      next_addr = chain_ptr;
    end else begin
      next_addr = cur_addr + STEP;
    end
  end

endmodule

// File: rtl/rxw_split.sv
module rxw_split #(
  parameter int FLW = 14
) (
  input  logic [FLW-1:0]            remain,
  input  logic [rxw_pkg::LEN_W-1:0] buf_len,
  output logic [rxw_pkg::LEN_W-1:0] chunk,
  output logic                      skip,
  output logic [FLW-1:0]            remain_after
);
  import rxw_pkg::*;

  logic [FLW-1:0] len_ext;
  logic [FLW-1:0] chunk_ext;

  always_comb begin
    len_ext      = FLW'(buf_len);
    chunk_ext    = (remain < len_ext) ? remain : len_ext;
    chunk        = chunk_ext[LEN_W-1:0];
    skip         = (buf_len == '0) || (remain == '0);
    remain_after = skip ? remain : (remain - chunk_ext);
  end

endmodule

// File: rtl/rxw_status.sv
module rxw_status (
  input  logic [3:0]  err,
  input  logic        first_seg,
  input  logic        last_seg,
  output logic [31:0] word
);
  import rxw_pkg::*;

  always_comb begin
    word            = '0;
    word[OWN_BIT]   = 1'b0;
    word[FIRST_BIT] = first_seg;
    word[LAST_BIT]  = last_seg;
    word[3:2]       = err[3:2];
    word[1:0]       = last_seg ? err[1:0] : 2'b00;
  end

endmodule

// File: rtl/rxw_walker.sv
module rxw_walker #(
  parameter int AW  = 32,
  parameter int FLW = 14
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      run_en,
  input  logic [AW-1:0]             list_base,
  output logic                      mem_rd_req,
  output logic [AW-1:0]             mem_rd_addr,
  input  logic                      mem_rd_ack,
  input  logic [31:0]               mem_rd_data,
  output logic                      mem_wr_req,
  output logic [AW-1:0]             mem_wr_addr,
  output logic [31:0]               mem_wr_data,
  input  logic                      mem_wr_ack,
  input  logic                      frm_valid,
  output logic                      frm_ready,
  input  logic [FLW-1:0]            frm_len,
  input  logic [3:0]                frm_err,
  output logic                      dma_req,
  output logic [AW-1:0]             dma_addr,
  output logic [rxw_pkg::LEN_W-1:0] dma_len,
  input  logic                      dma_ack
);
  import rxw_pkg::*;

  localparam int IDX_W = 2;

  // control state (reset)
  rxw_state_e        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [AW-1:0]     cur_q, cur_d;
  logic              busy_q, busy_d;
  logic              first_q, first_d;

  // datapath state (enable only)
  logic [LEN_W-1:0]  len1_q, len2_q;
  logic              eor_q, chn_q;
  logic [AW-1:0]     b1_q, b2_q;
  logic [FLW-1:0]    rem_q, rem_d;
  logic [3:0]        err_q;
  logic              ld_w1, ld_w2, ld_w3, ld_frame, ld_rem;

  // shared helpers
  logic [LEN_W-1:0]  sel_len;
  logic [LEN_W-1:0]  sp_chunk;
  logic              sp_skip;
  logic [FLW-1:0]    sp_rem;
  logic [AW-1:0]     nxt_addr;
  logic [31:0]       wb_word;
  logic              in_buf;

  assign sel_len = (state_q == ST_BUF2) ? len2_q : len1_q;
  assign in_buf  = (state_q == ST_BUF1) || (state_q == ST_BUF2);

  rxw_split #(.FLW(FLW)) u_split (
    .remain       (rem_q),
    .buf_len      (sel_len),
    .chunk        (sp_chunk),
    .skip         (sp_skip),
    .remain_after (sp_rem)
  );

  rxw_next_addr #(.AW(AW)) u_next (
    .cur_addr  (cur_q),
    .base_addr (list_base),
    .chain_ptr (b2_q),
    .end_ring  (eor_q),
    .chained   (chn_q),
    .next_addr (nxt_addr)
  );

  rxw_status u_status (
    .err       (err_q),
    .first_seg (first_q),
    .last_seg  (rem_q == '0),
    .word      (wb_word)
  );

  // next-state process
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    cur_d    = cur_q;
    busy_d   = busy_q;
    first_d  = first_q;
    rem_d    = rem_q;
    ld_w1    = 1'b0;
    ld_w2    = 1'b0;
    ld_w3    = 1'b0;
    ld_frame = 1'b0;
    ld_rem   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (run_en) begin
          cur_d   = list_base;
          idx_d   = '0;
          busy_d  = 1'b0;
          first_d = 1'b0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (mem_rd_ack) begin
          unique case (idx_q)
            2'd0: if (mem_rd_data[OWN_BIT]) idx_d = 2'd1;
            2'd1: begin ld_w1 = 1'b1; idx_d = 2'd2; end
            2'd2: begin ld_w2 = 1'b1; idx_d = 2'd3; end
            default: begin
              ld_w3   = 1'b1;
              idx_d   = 2'd0;
              first_d = 1'b0;
              state_d = busy_q ? ST_BUF1 : ST_WAITF;
            end
          endcase
        end
      end
      ST_WAITF: begin
        if (frm_valid) begin
          ld_frame = 1'b1;
          rem_d    = frm_len;
          busy_d   = 1'b1;
          first_d  = 1'b1;
          state_d  = ST_BUF1;
        end
      end
      ST_BUF1: begin
        if (sp_skip || dma_ack) begin
          ld_rem  = 1'b1;
          rem_d   = sp_rem;
          state_d = chn_q ? ST_WBACK : ST_BUF2;
        end
      end
      ST_BUF2: begin
        if (sp_skip || dma_ack) begin
          ld_rem  = 1'b1;
          rem_d   = sp_rem;
          state_d = ST_WBACK;
        end
      end
      ST_WBACK: begin
        if (mem_wr_ack) begin
          cur_d   = nxt_addr;
          busy_d  = (rem_q != '0);
          idx_d   = '0;
          state_d = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cur_q   <= '0;
      busy_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cur_q   <= cur_d;
      busy_q  <= busy_d;
      first_q <= first_d;
    end
  end

  // datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (ld_w1) begin
      len1_q <= mem_rd_data[LEN_W-1:0];
      len2_q <= mem_rd_data[2*LEN_W-1:LEN_W];
      eor_q  <= mem_rd_data[EOR_BIT];
      chn_q  <= mem_rd_data[CHN_BIT];
    end
    if (ld_w2) begin
      b1_q <= AW'(mem_rd_data);
    end
    if (ld_w3) begin
      b2_q <= AW'(mem_rd_data);
    end
    if (ld_frame) begin
      err_q <= frm_err;
    end
    if (ld_frame || ld_rem) begin
      rem_q <= rem_d;
    end
  end

  // outputs
  assign mem_rd_req  = (state_q == ST_FETCH);
  assign mem_rd_addr = cur_q + AW'({idx_q, 2'b00});
  assign mem_wr_req  = (state_q == ST_WBACK);
  assign mem_wr_addr = cur_q;
  assign mem_wr_data = wb_word;
  assign frm_ready   = (state_q == ST_WAITF);
  assign dma_req     = in_buf && !sp_skip;
  assign dma_addr    = (state_q == ST_BUF2) ? b2_q : b1_q;
  assign dma_len     = sp_chunk;

endmodule

// File: rtl/rxw_walker_chk.sv
module rxw_walker_chk #(
  parameter int AW = 32
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      mem_rd_req,
  input logic [AW-1:0]             mem_rd_addr,
  input logic                      mem_wr_req,
  input logic [31:0]               mem_wr_data,
  input logic                      frm_ready,
  input logic                      dma_req,
  input logic [AW-1:0]             dma_addr,
  input logic [rxw_pkg::LEN_W-1:0] dma_len,
  input logic                      dma_ack
);

  // R2
  rd_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> (mem_rd_addr[1:0] == 2'b00));

  // R4
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_rd_req, mem_wr_req, dma_req, frm_ready}));

  // R9
  dma_len_nz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (dma_len != '0));

  // R10
  wb_owner_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> !mem_wr_data[31]);

  // R11
  wb_tail_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_wr_data[8]) |-> (mem_wr_data[1:0] == 2'b00));

  // R12
  dma_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> (dma_req && $stable(dma_addr) && $stable(dma_len)));

endmodule

bind rxw_walker rxw_walker_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_rd_req  (mem_rd_req),
  .mem_rd_addr (mem_rd_addr),
  .mem_wr_req  (mem_wr_req),
  .mem_wr_data (mem_wr_data),
  .frm_ready   (frm_ready),
  .dma_req     (dma_req),
  .dma_addr    (dma_addr),
  .dma_len     (dma_len),
  .dma_ack     (dma_ack)
);

// File: tb/rxw_walker_test.sv
`timescale 1ns/1ps
module rxw_walker_test;

  localparam int AW  = 32;
  localparam int FLW = 14;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            run_en = 1'b0;
  logic [AW-1:0]   list_base = 32'h100;
  logic            mem_rd_req, mem_wr_req, frm_ready, dma_req;
  logic [AW-1:0]   mem_rd_addr, mem_wr_addr, dma_addr;
  logic [31:0]     mem_wr_data;
  logic            mem_rd_ack = 1'b0;
  logic [31:0]     mem_rd_data = '0;
  logic            mem_wr_ack = 1'b0;
  logic            frm_valid = 1'b0;
  logic [FLW-1:0]  frm_len = '0;
  logic [3:0]      frm_err = '0;
  logic [10:0]     dma_len;
  logic            dma_ack = 1'b0;

  always #2.5 clk = ~clk;

  rxw_walker #(.AW(AW), .FLW(FLW)) uut (.*);

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] mem [0:255];
  logic [31:0] rd_log [0:7];
  int          rd_n = 0;
  logic [31:0] wr_a [0:15];
  logic [31:0] wr_d [0:15];
  int          wr_n = 0;
  logic [31:0] dm_a [0:15];
  logic [10:0] dm_l [0:15];
  int          dm_n = 0;
  int          dm_wait = 0;
  logic [31:0] dm_a0;
  logic [10:0] dm_l0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_w1(input bit eor, input bit chn,
                                        input int l2, input int l1);
    logic [31:0] w;
    w = '0;
    w[25] = eor;
    w[24] = chn;
    w[21:11] = l2[10:0];
    w[10:0] = l1[10:0];
    return w;
  endfunction

  task automatic put_desc(input int addr, input bit own, input logic [31:0] w1,
                          input int a1, input int a2);
    mem[addr/4]     = own ? 32'h8000_0000 : 32'h0;
    mem[addr/4 + 1] = w1;
    mem[addr/4 + 2] = a1;
    mem[addr/4 + 3] = a2;
  endtask

  // memory and DMA responders, driven away from the rising edge
  always @(negedge clk) begin
    mem_rd_ack  = mem_rd_req;
    mem_rd_data = mem_rd_req ? mem[mem_rd_addr[9:2]] : 32'h0;
    if (mem_rd_req && rd_n < 8) begin
      rd_log[rd_n] = mem_rd_addr;
      rd_n++;
    end
    mem_wr_ack = mem_wr_req;
    if (mem_wr_req) begin
      mem[mem_wr_addr[9:2]] = mem_wr_data;
      if (wr_n < 16) begin
        wr_a[wr_n] = mem_wr_addr;
        wr_d[wr_n] = mem_wr_data;
      end
      wr_n++;
    end
    if (dma_req) begin
      if (dm_wait == 0) begin
        dm_a0 = dma_addr;
        dm_l0 = dma_len;
      end
      if (dm_wait == 2) begin
        dma_ack = 1'b1;
        // R12 request held steady while waiting for acknowledge
        chk("R12 hold", {dma_addr ^ dm_a0} | {21'h0, dma_len ^ dm_l0}, 32'h0);
        if (dm_n < 16) begin
          dm_a[dm_n] = dma_addr;
          dm_l[dm_n] = dma_len;
        end
        dm_n++;
        dm_wait = 0;
      end else begin
        dma_ack = 1'b0;
        dm_wait++;
      end
    end else begin
      dma_ack = 1'b0;
      dm_wait = 0;
    end
  end

  task automatic send_frame(input int len, input logic [3:0] err);
    int guard;
    guard = 0;
    @(negedge clk);
    frm_valid = 1'b1;
    frm_len   = FLW'(len);
    frm_err   = err;
    while (!frm_ready && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic wait_wr(input int n);
    int guard;
    guard = 0;
    while (wr_n < n && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    chk("writeback count", wr_n, n);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 idle until run_en
    chk("R1 idle outputs", {28'h0, mem_rd_req, mem_wr_req, dma_req, frm_ready}, 32'h0);
    chk("R1 no reads", rd_n, 0);
    run_en = 1'b1;
  endtask

  task automatic t_fit_single;
    int guard;
    guard = 0;
    while (!frm_ready && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    // R4 ready only after a full descriptor read
    chk("R4 ready after fetch", rd_n, 4);
    // R2 word order and addresses
    chk("R2 word0", rd_log[0], 32'h100);
    chk("R2 word1", rd_log[1], 32'h104);
    chk("R2 word2", rd_log[2], 32'h108);
    chk("R2 word3", rd_log[3], 32'h10C);
    send_frame(60, 4'b0000);
    wait_wr(1);
    // R5 buffer 1 segment
    chk("R5 dma addr", dm_a[0], 32'h1000);
    chk("R5 dma len", dm_l[0], 60);
    // R10 single-descriptor frame status
    chk("R10 wb addr", wr_a[0], 32'h100);
    chk("R10 wb data", wr_d[0], 32'h300);
  endtask

  task automatic t_spill;
    send_frame(200, 4'b1111);
    wait_wr(3);
    // R6 spill to buffer 2 then to next descriptor
    chk("R6 b1 addr", dm_a[1], 32'h2000);
    chk("R6 b1 len", dm_l[1], 100);
    chk("R6 b2 addr", dm_a[2], 32'h2400);
    chk("R6 b2 len", dm_l[2], 50);
    chk("R6 next desc addr", dm_a[3], 32'h3000);
    chk("R6 next desc len", dm_l[3], 50);
    // R8 ring step of 16
    chk("R8 step wb addr", wr_a[1], 32'h110);
    // R10 first segment keeps bits 3:2; R11 no CRC/overflow before the end
    chk("R11 mid desc status", wr_d[1], 32'h20C);
    chk("R11 end desc status", wr_d[2], 32'h10F);
    // R7 chained buffer 2 length ignored, no request to word 3
    chk("R7 dma count", dm_n, 4);
  endtask

  task automatic t_chain_eor;
    send_frame(45, 4'b0000);
    wait_wr(5);
    // R8 chain pointer followed
    chk("R8 chain wb addr", wr_a[3], 32'h200);
    chk("R7 chained len", dm_l[4], 30);
    chk("R7 chained addr", dm_a[4], 32'h4000);
    chk("R8 chain2 wb addr", wr_a[4], 32'h240);
    // R9 zero-length buffer 1 skipped
    chk("R9 skip addr", dm_a[5], 32'h5400);
    chk("R9 skip len", dm_l[5], 15);
    chk("R9 dma count", dm_n, 6);
    chk("R10 chain first", wr_d[3], 32'h200);
    chk("R10 chain last", wr_d[4], 32'h100);
  endtask

  task automatic t_stall;
    repeat (20) @(negedge clk);
    // R3 owner clear: polling word 0 at the list base (R8 end of ring)
    chk("R8 eor return", mem_rd_addr, 32'h100);
    chk("R3 stalled ready", {31'h0, frm_ready}, 32'h0);
    chk("R3 stalled req", {31'h0, mem_rd_req}, 32'h1);
    chk("R3 no writes", wr_n, 5);
    mem[32'h100/4] = 32'h8000_0000;
    send_frame(10, 4'b0011);
    wait_wr(6);
    chk("R3 resumed dma", dm_a[6], 32'h1000);
    chk("R3 resumed len", dm_l[6], 10);
    chk("R11 end bits written", wr_d[5], 32'h303);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    put_desc(32'h100, 1'b1, mk_w1(1'b0, 1'b0, 50, 100),  32'h1000, 32'h1800);
    put_desc(32'h110, 1'b1, mk_w1(1'b0, 1'b0, 50, 100),  32'h2000, 32'h2400);
    put_desc(32'h120, 1'b1, mk_w1(1'b0, 1'b1, 2000, 80), 32'h3000, 32'h200);
    put_desc(32'h200, 1'b1, mk_w1(1'b0, 1'b1, 500, 30),  32'h4000, 32'h240);
    put_desc(32'h240, 1'b1, mk_w1(1'b1, 1'b0, 40, 0),    32'h5000, 32'h5400);
    t_reset();
    t_fit_single();
    t_spill();
    t_chain_eor();
    t_stall();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule